// File: doc/BRIEF.md
# Timed interrupt-disable counter

This block sits in a processor's interrupt path and holds off ordinary-priority interrupt requests for a programmed number of instruction cycles. When a timed-disable instruction completes, the decoder pulses a load strobe with the immediate value N. The block masks interrupts in that cycle and then for N more instruction cycles, so N+1 cycles are masked in total. Software can also write the count directly. Writing zero ends the hold early.

The count only moves on cycles where the instruction-cycle enable is high, so a pipeline stall does not use up any of the masking window. The mask output is derived from the live count and the load strobe, never from a separate state machine. As a result, a new load that arrives on the cycle the count first reads zero re-arms masking without a gap. A per-request priority level selects whether the current request is held off. Only levels 1 to 6 can be blocked, and the top level always passes.

Top module: `intr_holdoff`

## Requirements
- R1: After reset the count reads 0 and the hold output is low.
- R2: The hold output is high in exactly those cycles where the load strobe is high or the count is nonzero.
- R3: A load of value N with the cycle enable held high gives exactly N+1 consecutive cycles of hold, including the cycle of the strobe itself; N=0 gives one cycle.
- R4: The count decrements by one only in cycles with the cycle enable high; with the enable low it holds its value.
- R5: A load while the count is nonzero replaces the count with the new value on the next cycle.
- R6: A load in the cycle where the count has just reached zero keeps hold high in that cycle and loads the new value, with no unmasked cycle in between.
- R7: A software write sets the count on the next cycle; a write of zero drops hold on the next cycle.
- R8: When a load strobe and a software write occur in the same cycle, the count takes the load value.
- R9: The block output is high only when hold is high and the 3-bit unsigned request level is between 1 and 6 inclusive; levels 0 and 7 are never blocked.
- R10: The count is 14 bits wide by default and holds 0x1FFF without truncation, readable on the count output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_en | input | 1 | Instruction-cycle enable; gates the decrement |
| ld_stb | input | 1 | Load strobe from a completing disable instruction |
| ld_val | input | CNT_W | Immediate count loaded by the strobe |
| sw_wr | input | 1 | Software write strobe to the count |
| sw_val | input | CNT_W | Software write data |
| req_lvl | input | 3 | Priority level of the current request |
| hold_active | output | 1 | Masking window is open |
| lvl_block | output | 1 | Current request is held off |
| cnt_rd | output | CNT_W | Readable current count |

## Verification
The hardest case to reach is a reload that lands on the exact cycle the count first reads zero, because it needs the bench to know the count's phase. The stimulus loads a small value, counts enabled cycles until the readable count shows zero, and pulses the load in that same cycle. It then checks that hold never dropped and that the new value is taken. A variant reloads while the count is one, and a stall test shows that cycles with the enable low do not move that phase.

// File: rtl/intr_holdoff.sv
module intr_holdoff #(
  parameter int CNT_W   = 14,
  parameter int LVL_W   = 3,
  parameter int LVL_MIN = 1,
  parameter int LVL_MAX = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic             ld_stb,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             sw_wr,
  input  logic [CNT_W-1:0] sw_val,
  input  logic [LVL_W-1:0] req_lvl,
  output logic             hold_active,
  output logic             lvl_block,
  output logic [CNT_W-1:0] cnt_rd
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             cnt_live;
  logic             lvl_in_band;

  assign cnt_live    = |cnt_q;
  assign hold_active = ld_stb | cnt_live;
  assign lvl_in_band = (req_lvl >= LVL_W'(LVL_MIN)) && (req_lvl <= LVL_W'(LVL_MAX));
  assign lvl_block   = hold_active & lvl_in_band;
  assign cnt_rd      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (ld_stb)
      cnt_q <= ld_val;
    else if (sw_wr)
      cnt_q <= sw_val;
    else if (cyc_en && cnt_live)
      cnt_q <= cnt_q - ONE;
  end

  // R2
  strobe_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb |-> hold_active);

  // R5 R8
  load_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb |=> cnt_rd == $past(ld_val));

  // R7
  sw_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && !ld_stb) |=> cnt_rd == $past(sw_val));

  // R4
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_stb && !sw_wr && cyc_en && cnt_rd != '0) |=> cnt_rd == $past(cnt_rd) - ONE);

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_stb && !sw_wr && !cyc_en) |=> $stable(cnt_rd));

  // R9
  top_level_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_lvl == '1 || req_lvl == '0) |-> !lvl_block);

endmodule

// File: tb/test_intr_holdoff.sv
module test_intr_holdoff;
  localparam int CNT_W = 14;

  logic             clk = 0;
  logic             rst_n = 0;
  logic             cyc_en = 0;
  logic             ld_stb = 0;
  logic [CNT_W-1:0] ld_val = '0;
  logic             sw_wr = 0;
  logic [CNT_W-1:0] sw_val = '0;
  logic [2:0]       req_lvl = '0;
  logic             hold_active;
  logic             lvl_block;
  logic [CNT_W-1:0] cnt_rd;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  intr_holdoff #(.CNT_W(CNT_W)) i_intr_holdoff (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ld_stb(ld_stb), .ld_val(ld_val),
    .sw_wr(sw_wr), .sw_val(sw_val), .req_lvl(req_lvl),
    .hold_active(hold_active), .lvl_block(lvl_block), .cnt_rd(cnt_rd)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic idle();
    ld_stb = 0; sw_wr = 0; cyc_en = 1;
  endtask

  task automatic clear();
    idle(); sw_wr = 1; sw_val = '0; tick(); sw_wr = 0; tick();
  endtask

  task automatic t_reset();
    check("R1 count", int'(cnt_rd), 0);
    check("R1 hold", int'(hold_active), 0);
  endtask

  task automatic t_span(input int n);
    int masked = 0;
    idle(); ld_stb = 1; ld_val = CNT_W'(n);
    #1;
    check("R2 hold on strobe", int'(hold_active), 1);
    if (hold_active) masked++;
    tick(); ld_stb = 0; #1;
    for (int i = 0; i < 100 && hold_active; i++) begin
      if (cnt_rd == '0) check("R2 hold with zero count", int'(hold_active), 0);
      masked++;
      tick();
    end
    check("R3 masked cycles", masked, n + 1);
    check("R2 hold low at end", int'(hold_active), 0);
  endtask

  task automatic t_stall();
    idle(); ld_stb = 1; ld_val = 4; tick(); ld_stb = 0; cyc_en = 0;
    check("R4 loaded", int'(cnt_rd), 4);
    tick(); tick(); tick();
    check("R4 stall holds count", int'(cnt_rd), 4);
    check("R2 hold during stall", int'(hold_active), 1);
    cyc_en = 1; tick();
    check("R4 resumes", int'(cnt_rd), 3);
    clear();
  endtask

  task automatic t_reload_busy();
    idle(); ld_stb = 1; ld_val = 10; tick(); ld_stb = 0;
    tick(); tick(); tick();
    check("R5 before reload", int'(cnt_rd), 7);
    ld_stb = 1; ld_val = 2; tick(); ld_stb = 0;
    check("R5 replaced", int'(cnt_rd), 2);
    clear();
  endtask

  task automatic t_reload_zero();
    int gaps = 0;
    idle(); ld_stb = 1; ld_val = 2; tick(); ld_stb = 0;
    for (int i = 0; i < 10 && cnt_rd != '0; i++) tick();
    check("R6 count reached zero", int'(cnt_rd), 0);
    ld_stb = 1; ld_val = 3; #1;
    check("R6 hold in zero cycle", int'(hold_active), 1);
    tick(); ld_stb = 0;
    check("R6 new count", int'(cnt_rd), 3);
    for (int i = 0; i < 3; i++) begin
      if (!hold_active) gaps++;
      tick();
    end
    check("R6 no gap after rearm", gaps, 0);
    check("R6 window ends", int'(hold_active), 0);
    ld_stb = 1; ld_val = 2; tick(); ld_stb = 0; tick();
    check("R6 count at one", int'(cnt_rd), 1);
    ld_stb = 1; ld_val = 5; tick(); ld_stb = 0;
    check("R6 reload at one", int'(cnt_rd), 5);
    check("R6 hold kept", int'(hold_active), 1);
    clear();
  endtask

  task automatic t_sw();
    idle(); ld_stb = 1; ld_val = 9; tick(); ld_stb = 0;
    sw_wr = 1; sw_val = 0; tick(); sw_wr = 0;
    check("R7 write zero count", int'(cnt_rd), 0);
    check("R7 write zero hold", int'(hold_active), 0);
    sw_wr = 1; sw_val = 6; tick(); sw_wr = 0;
    check("R7 write value", int'(cnt_rd), 6);
    check("R7 hold after write", int'(hold_active), 1);
    clear();
  endtask

  task automatic t_prio();
    idle(); ld_stb = 1; ld_val = 3; sw_wr = 1; sw_val = 8; tick();
    ld_stb = 0; sw_wr = 0;
    check("R8 load wins", int'(cnt_rd), 3);
    clear();
  endtask

  task automatic t_lvl();
    idle(); cyc_en = 0; sw_wr = 1; sw_val = 5; tick(); sw_wr = 0;
    for (int l = 0; l < 8; l++) begin
      req_lvl = 3'(l); #1;
      check("R9 block while held", int'(lvl_block), (l >= 1 && l <= 6) ? 1 : 0);
    end
    clear();
    for (int l = 0; l < 8; l++) begin
      req_lvl = 3'(l); #1;
      check("R9 no block when idle", int'(lvl_block), 0);
    end
  endtask

  task automatic t_wide();
    idle(); ld_stb = 1; ld_val = 14'h1FFF; tick(); ld_stb = 0;
    check("R10 full count", int'(cnt_rd), 'h1FFF);
    tick();
    check("R10 decrement", int'(cnt_rd), 'h1FFE);
    clear();
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1;
    tick();
    t_reset();
    t_span(0);
    t_span(1);
    t_span(5);
    t_stall();
    t_reload_busy();
    t_reload_zero();
    t_sw();
    t_prio();
    t_lvl();
    t_wide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule